// File: doc/BRIEF.md
# Key-Protected System Control Register File

This block holds the core-level system control words that sit in a 4 KB control window at offsets 0xD08 through 0xD24. It stores the exception vector table base, twelve 8-bit system-handler priorities packed four to a 32-bit word, and the three fault-class enables. It also decodes a guarded control word that, only when the correct 16-bit key is supplied in the upper halfword, emits a one-cycle system reset request or a one-cycle request to clear active exception state.

Accesses arrive as single-cycle strobes with an address, a write flag and write data. Read data and a bad-access flag are returned combinationally in the same cycle. A write takes effect at the clock edge on which the strobe is sampled. The handler status word combines live active and pending flags from the exception logic with the writable enables held here. Any offset outside the mapped set is flagged, including the fault status and fault address range and any unaligned address.

Top module: `sysctl_regfile`

## Requirements
- R1: After synchronous reset, `vec_base`, every byte of `handler_prio` and `fault_en` are zero, and neither request output is high.
- R2: A write to 0xD08 stores bits [31:7] of the data. Bits [6:0] read as zero, both on `vec_base` and when 0xD08 is read.
- R3: A write to 0xD0C whose bits [31:16] equal 0x05FA and that has bit 0 or bit 2 set drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R4: A write to 0xD0C whose bits [31:16] equal 0x05FA and that has bit 1 set drives `clr_active_req` high for exactly the one cycle after the write edge.
- R5: A write to 0xD0C with any other upper halfword raises no request and changes no stored state.
- R6: A read of 0xD0C always returns 0x0FA05000.
- R7: Offsets 0xD18, 0xD1C and 0xD20 each hold four priorities. Byte lane k of the word at offset A belongs to handler (A - 0xD14) + k, with lane 0 in bits [7:0]. Handler n (4..15) appears on `handler_prio[(n-4)*8 +: 8]` and reads back from its lane.
- R8: In the word at 0xD24, bits 16, 17 and 18 are writable enables for the memory, bus and usage faults. They appear on `fault_en` bits 0, 1 and 2.
- R9: A read of 0xD24 returns active flags `exc_active` bits 0..6 (memory, bus, usage, supervisor call, debug, pended service, tick) at bit positions 0, 1, 3, 7, 8, 10 and 11. It returns pending flags `exc_pending` bits 0..3 (usage, memory, bus, supervisor call) at positions 12..15. All other bits below 16 and above 18 read zero, and writes to these bits are ignored.
- R10: An access to any offset other than 0xD08, 0xD0C, 0xD18, 0xD1C, 0xD20 and 0xD24 raises `acc_bad` and reads zero. This covers 0xD10, 0xD14, the range 0xD28 to 0xD3C and any address with nonzero bits [1:0]. A write to such an offset changes nothing.
- R11: `acc_bad` is low for accesses to mapped offsets and whenever `acc_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset within the control window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the addressed word |
| acc_bad | output | 1 | Access targets an unmapped or unaligned offset |
| exc_active | input | 7 | Active flags: mem, bus, usage, svc, debug, pended service, tick |
| exc_pending | input | 4 | Pending flags: usage, mem, bus, svc |
| vec_base | output | 32 | Vector table base, low 7 bits zero |
| sys_reset_req | output | 1 | One-cycle system reset request |
| clr_active_req | output | 1 | One-cycle request to clear active state |
| handler_prio | output | 96 | Priorities of handlers 4..15, 8 bits each |
| fault_en | output | 3 | Fault enables: mem, bus, usage |

## Verification
The hardest condition to reach is a write that carries an almost-correct key: the right register with the wrong key, or the right key aimed at a fault-status or reserved offset. Either one must leave every output untouched. The bench builds these cases on purpose. It uses keys one bit away from the real one and reset-shaped data sent to neighbouring offsets. Between these writes it checks every stored field at the ports. It also sweeps every word offset in the window to check the decode, and it sweeps all 2048 combinations of active and pending flags to check the bit packing of the status word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int ADDR_W        = 12;
    localparam int DATA_W        = 32;
    localparam int PRIO_W        = 8;
    localparam int PRIO_LANES    = DATA_W / PRIO_W;
    localparam int PRIO_WORDS    = 3;
    localparam int NUM_PRIO      = PRIO_WORDS * PRIO_LANES;
    localparam int PRIO_IDX_W    = (PRIO_WORDS > 1) ? $clog2(PRIO_WORDS) : 1;
    localparam int FIRST_HANDLER = 4;
    localparam int VEC_LSB       = 7;
    localparam int KEY_W         = 16;
    localparam int NUM_ACT       = 7;
    localparam int NUM_PEND      = 4;
    localparam int NUM_FEN       = 3;
    localparam int FEN_LSB       = 16;

    localparam logic [KEY_W-1:0]  WR_KEY    = 16'h05FA;
    localparam logic [DATA_W-1:0] RSTCTL_RD = 32'h0FA0_5000;

    localparam logic [ADDR_W-1:0] OFF_VEC    = 12'hD08;
    localparam logic [ADDR_W-1:0] OFF_RSTCTL = 12'hD0C;
    localparam logic [ADDR_W-1:0] OFF_PRIO0  = 12'hD18;
    localparam logic [ADDR_W-1:0] OFF_HSTAT  = 12'hD24;
    localparam logic [ADDR_W-1:0] OFF_PRIO_END =
        OFF_PRIO0 + ADDR_W'(4 * PRIO_WORDS);

    // bit positions of the status flags inside the handler status word
    localparam int ACT_POS [NUM_ACT]   = '{0, 1, 3, 7, 8, 10, 11};
    localparam int PEND_POS [NUM_PEND] = '{12, 13, 14, 15};

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VEC,
        SEL_RSTCTL,
        SEL_PRIO,
        SEL_HSTAT
    } sel_e;

    typedef struct packed {
        sel_e                  sel;
        logic [PRIO_IDX_W-1:0] word;
    } dec_t;

    typedef struct packed {
        logic tick;
        logic pendsv;
        logic debug;
        logic svc;
        logic usage;
        logic bus;
        logic mem;
    } act_t;

    typedef struct packed {
        logic svc;
        logic bus;
        logic mem;
        logic usage;
    } pend_t;

    typedef struct packed {
        logic usage;
        logic bus;
        logic mem;
    } fen_t;

    function automatic dec_t decode_offset(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.sel  = SEL_NONE;
        d.word = '0;
        if (a[1:0] == 2'b00) begin
            if (a == OFF_VEC) begin
                d.sel = SEL_VEC;
            end else if (a == OFF_RSTCTL) begin
                d.sel = SEL_RSTCTL;
            end else if (a == OFF_HSTAT) begin
                d.sel = SEL_HSTAT;
            end else if (a >= OFF_PRIO0 && a < OFF_PRIO_END) begin
                d.sel  = SEL_PRIO;
                d.word = PRIO_IDX_W'((a - OFF_PRIO0) >> 2);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic              acc_en,
    input  logic [ADDR_W-1:0] acc_addr,
    output dec_t              dec,
    output logic              bad
);

    always_comb begin
        dec = decode_offset(acc_addr);
        bad = acc_en && (dec.sel == SEL_NONE);
    end

endmodule

// File: rtl/sysctl_prio_bank.sv
module sysctl_prio_bank
    import sysctl_pkg::*;
#(
    parameter int WORDS = PRIO_WORDS,
    parameter int LANES = PRIO_LANES,
    parameter int W     = PRIO_W,
    parameter int IDX_W = PRIO_IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         word,
    input  logic [LANES*W-1:0]       wdata,
    output logic [WORDS*LANES*W-1:0] prio_flat,
    output logic [LANES*W-1:0]       rd_word
);

    localparam int WORD_BITS = LANES * W;

    logic [WORD_BITS-1:0] bank [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[w] <= '0;
            end else if (wr_en && (word == IDX_W'(w))) begin
                bank[w] <= wdata;
            end
        end
        // lane 0 of each word is its lowest-numbered handler
        assign prio_flat[w*WORD_BITS +: WORD_BITS] = bank[w];
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word == IDX_W'(w)) begin
                rd_word = bank[w];
            end
        end
    end

endmodule

// File: rtl/sysctl_keyed_ctrl.sv
module sysctl_keyed_ctrl
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] key,
    input  logic [2:0]       cmd,
    output logic             sys_reset_req,
    output logic             clr_active_req
);

    logic key_ok;

    always_comb begin
        key_ok = wr_en && (key == WR_KEY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_reset_req  <= 1'b0;
            clr_active_req <= 1'b0;
        end else begin
            sys_reset_req  <= key_ok && (cmd[0] || cmd[2]);
            clr_active_req <= key_ok && cmd[1];
        end
    end

endmodule

// File: rtl/sysctl_hstat.sv
module sysctl_hstat
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [NUM_FEN-1:0] fen_wdata,
    input  act_t              act,
    input  pend_t             pend,
    output fen_t              fen,
    output logic [DATA_W-1:0] rd_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fen <= '0;
        end else if (wr_en) begin
            fen <= fen_t'(fen_wdata);
        end
    end

    logic [NUM_ACT-1:0]  act_v;
    logic [NUM_PEND-1:0] pend_v;

    always_comb begin
        act_v  = act;
        pend_v = pend;
        rd_word = '0;
        for (int i = 0; i < NUM_ACT; i++) begin
            rd_word[ACT_POS[i]] = act_v[i];
        end
        for (int i = 0; i < NUM_PEND; i++) begin
            rd_word[PEND_POS[i]] = pend_v[i];
        end
        rd_word[FEN_LSB +: NUM_FEN] = fen;
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_en,
    input  logic                       acc_wr,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [DATA_W-1:0]          acc_wdata,
    output logic [DATA_W-1:0]          acc_rdata,
    output logic                       acc_bad,
    input  logic [NUM_ACT-1:0]         exc_active,
    input  logic [NUM_PEND-1:0]        exc_pending,
    output logic [DATA_W-1:0]          vec_base,
    output logic                       sys_reset_req,
    output logic                       clr_active_req,
    output logic [NUM_PRIO*PRIO_W-1:0] handler_prio,
    output logic [NUM_FEN-1:0]         fault_en
);

    dec_t dec;
    logic wr;

    sysctl_decode u_decode (
        .acc_en   (acc_en),
        .acc_addr (acc_addr),
        .dec      (dec),
        .bad      (acc_bad)
    );

    always_comb begin
        wr = acc_en && acc_wr;
    end

    // vector table base: low bits are hard zero
    logic [DATA_W-1:VEC_LSB] vec_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_hi <= '0;
        end else if (wr && dec.sel == SEL_VEC) begin
            vec_hi <= acc_wdata[DATA_W-1:VEC_LSB];
        end
    end

    always_comb begin
        vec_base = {vec_hi, {VEC_LSB{1'b0}}};
    end

    sysctl_keyed_ctrl u_keyed (
        .clk            (clk),
        .rst            (rst),
        .wr_en          (wr && dec.sel == SEL_RSTCTL),
        .key            (acc_wdata[DATA_W-1:DATA_W-KEY_W]),
        .cmd            (acc_wdata[2:0]),
        .sys_reset_req  (sys_reset_req),
        .clr_active_req (clr_active_req)
    );

    logic [DATA_W-1:0] prio_rd;

    sysctl_prio_bank u_prio (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr && dec.sel == SEL_PRIO),
        .word      (dec.word),
        .wdata     (acc_wdata),
        .prio_flat (handler_prio),
        .rd_word   (prio_rd)
    );

    fen_t              fen;
    logic [DATA_W-1:0] hstat_rd;

    sysctl_hstat u_hstat (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr && dec.sel == SEL_HSTAT),
        .fen_wdata (acc_wdata[FEN_LSB +: NUM_FEN]),
        .act       (act_t'(exc_active)),
        .pend      (pend_t'(exc_pending)),
        .fen       (fen),
        .rd_word   (hstat_rd)
    );

    always_comb begin
        fault_en = fen;
    end

    always_comb begin
        unique case (dec.sel)
            SEL_VEC:    acc_rdata = vec_base;
            SEL_RSTCTL: acc_rdata = RSTCTL_RD;
            SEL_PRIO:   acc_rdata = prio_rd;
            SEL_HSTAT:  acc_rdata = hstat_rd;
            default:    acc_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       acc_en,
    input logic                       acc_wr,
    input logic [ADDR_W-1:0]          acc_addr,
    input logic [DATA_W-1:0]          acc_wdata,
    input logic                       acc_bad,
    input logic [DATA_W-1:0]          vec_base,
    input logic                       sys_reset_req,
    input logic                       clr_active_req,
    input logic [NUM_PRIO*PRIO_W-1:0] handler_prio,
    input logic [NUM_FEN-1:0]         fault_en
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    logic wr_any, wr_vec, wr_rst, wr_hstat, key_match;

    always_comb begin
        wr_any    = acc_en && acc_wr;
        wr_vec    = wr_any && acc_addr == OFF_VEC;
        wr_rst    = wr_any && acc_addr == OFF_RSTCTL;
        wr_hstat  = wr_any && acc_addr == OFF_HSTAT;
        key_match = acc_wdata[DATA_W-1:DATA_W-KEY_W] == WR_KEY;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (vec_base == '0 && handler_prio == '0 && fault_en == '0
                 && !sys_reset_req && !clr_active_req));

    a_r2_vec_written: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(wr_vec) |->
            vec_base == {$past(acc_wdata[DATA_W-1:VEC_LSB]), {VEC_LSB{1'b0}}});

    a_r3_reset_cause: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |->
            past_ok && $past(wr_rst && key_match && (acc_wdata[0] || acc_wdata[2])));

    a_r4_clear_cause: assert property (@(posedge clk) disable iff (rst)
        clr_active_req |-> past_ok && $past(wr_rst && key_match && acc_wdata[1]));

    a_r5_bad_key_quiet: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(wr_rst && !key_match) |-> !sys_reset_req && !clr_active_req);

    a_r8_enables_hold: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(wr_hstat) |-> $stable(fault_en));

    a_r10_bad_write_inert: assert property (@(posedge clk) disable iff (rst)
        wr_any && acc_bad |=>
            ($stable(vec_base) && $stable(handler_prio) && $stable(fault_en)
             && !sys_reset_req && !clr_active_req));

    a_r11_idle_not_bad: assert property (@(posedge clk) disable iff (rst)
        !acc_en |-> !acc_bad);

endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .acc_en         (acc_en),
    .acc_wr         (acc_wr),
    .acc_addr       (acc_addr),
    .acc_wdata      (acc_wdata),
    .acc_bad        (acc_bad),
    .vec_base       (vec_base),
    .sys_reset_req  (sys_reset_req),
    .clr_active_req (clr_active_req),
    .handler_prio   (handler_prio),
    .fault_en       (fault_en)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [11:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_bad;
    logic [6:0]  exc_active = '0;
    logic [3:0]  exc_pending = '0;
    logic [31:0] vec_base;
    logic        sys_reset_req;
    logic        clr_active_req;
    logic [95:0] handler_prio;
    logic [2:0]  fault_en;

    int total = 0;
    int bad = 0;

    // bench-side model of the stored state
    logic [31:0] m_vec;
    logic [7:0]  m_prio [4:15];
    logic [2:0]  m_fen;

    sysctl_regfile u_sysctl_regfile (
        .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_bad(acc_bad), .exc_active(exc_active), .exc_pending(exc_pending),
        .vec_base(vec_base), .sys_reset_req(sys_reset_req),
        .clr_active_req(clr_active_req), .handler_prio(handler_prio),
        .fault_en(fault_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [11:0] a, output logic [31:0] d, output logic b);
        acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1;
        d = acc_rdata;
        b = acc_bad;
        acc_en = 1'b0;
        #1;
    endtask

    function automatic bit is_mapped(input logic [11:0] a);
        return a == 12'hD08 || a == 12'hD0C || a == 12'hD18 ||
               a == 12'hD1C || a == 12'hD20 || a == 12'hD24;
    endfunction

    function automatic logic [31:0] exp_hstat(input logic [6:0] a, input logic [3:0] p,
                                              input logic [2:0] f);
        logic [31:0] w;
        w = '0;
        w[0] = a[0]; w[1] = a[1]; w[3] = a[2]; w[7] = a[3];
        w[8] = a[4]; w[10] = a[5]; w[11] = a[6];
        w[15:12] = p;
        w[18:16] = f;
        return w;
    endfunction

    task automatic check_state(input string req);
        chk(req, vec_base, m_vec);
        chk(req, {29'd0, fault_en}, {29'd0, m_fen});
        for (int n = 4; n < 16; n++) begin
            chk(req, {24'd0, handler_prio[(n-4)*8 +: 8]}, {24'd0, m_prio[n]});
        end
        chk(req, {30'd0, sys_reset_req, clr_active_req}, 32'd0);
    endtask

    task automatic model_reset();
        m_vec = '0;
        m_fen = '0;
        for (int n = 4; n < 16; n++) m_prio[n] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        b;

        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the ports and on readback
        check_state("R1");
        do_rd(12'hD18, d, b); chk("R1", d, 32'd0);
        do_rd(12'hD24, d, b); chk("R1", d, 32'd0);

        // R10 R11: decode sweep over every word offset plus unaligned ones
        for (int i = 0; i < 1024; i++) begin
            logic [11:0] a;
            a = 12'(i * 4);
            do_rd(a, d, b);
            chk("R10_R11 bad flag", {31'd0, b}, {31'd0, !is_mapped(a)});
            if (!is_mapped(a)) chk("R10 read zero", d, 32'd0);
        end
        for (int i = 1; i < 4; i++) begin
            do_rd(12'hD08 + 12'(i), d, b);
            chk("R10 unaligned", {31'd0, b}, 32'd1);
        end
        #1;
        chk("R11 idle", {31'd0, acc_bad}, 32'd0);

        // R2: vector base keeps bits [31:7]
        do_wr(12'hD08, 32'hFFFF_FFFF); m_vec = 32'hFFFF_FF80;
        chk("R2", vec_base, m_vec);
        do_rd(12'hD08, d, b); chk("R2", d, m_vec);
        do_wr(12'hD08, 32'h1234_567F); m_vec = 32'h1234_5600;
        chk("R2", vec_base, m_vec);
        do_rd(12'hD08, d, b); chk("R2", d, m_vec);

        // R3: keyed reset request, bit 0 and bit 2
        for (int c = 0; c < 2; c++) begin
            do_wr(12'hD0C, c == 0 ? 32'h05FA_0001 : 32'h05FA_0004);
            chk("R3 pulse", {31'd0, sys_reset_req}, 32'd1);
            chk("R3 no clear", {31'd0, clr_active_req}, 32'd0);
            @(negedge clk);
            chk("R3 single", {31'd0, sys_reset_req}, 32'd0);
        end
        // R4: keyed clear-active request, then both together
        do_wr(12'hD0C, 32'h05FA_0002);
        chk("R4 pulse", {31'd0, clr_active_req}, 32'd1);
        chk("R4 no reset", {31'd0, sys_reset_req}, 32'd0);
        @(negedge clk);
        chk("R4 single", {31'd0, clr_active_req}, 32'd0);
        do_wr(12'hD0C, 32'h05FA_0003);
        chk("R3_R4 both", {30'd0, sys_reset_req, clr_active_req}, 32'd3);
        @(negedge clk);

        // R5: near-miss keys do nothing
        do_wr(12'hD0C, 32'h05FB_0007); check_state("R5");
        do_wr(12'hD0C, 32'h85FA_0007); check_state("R5");
        do_wr(12'hD0C, 32'h0000_0007); check_state("R5");

        // R6: fixed readback
        do_rd(12'hD0C, d, b); chk("R6", d, 32'h0FA0_5000);

        // R7: priority byte lanes, two patterns
        for (int p = 0; p < 2; p++) begin
            for (int w = 0; w < 3; w++) begin
                logic [31:0] wd;
                logic [11:0] a;
                a = 12'hD18 + 12'(w * 4);
                for (int k = 0; k < 4; k++) begin
                    int n;
                    n = int'(a) - 'hD14 + k;
                    m_prio[n] = 8'((n * 37 + 11) ^ (p * 8'hFF));
                    wd[k*8 +: 8] = m_prio[n];
                end
                do_wr(a, wd);
            end
            check_state("R7");
            for (int w = 0; w < 3; w++) begin
                logic [11:0] a;
                a = 12'hD18 + 12'(w * 4);
                do_rd(a, d, b);
                for (int k = 0; k < 4; k++) begin
                    chk("R7 readback lane", {24'd0, d[k*8 +: 8]},
                        {24'd0, m_prio[int'(a) - 'hD14 + k]});
                end
            end
        end

        // R8: each enable alone, then all
        for (int i = 0; i < 3; i++) begin
            do_wr(12'hD24, 32'h1 << (16 + i));
            m_fen = 3'(1 << i);
            chk("R8 enable", {29'd0, fault_en}, {29'd0, m_fen});
        end
        do_wr(12'hD24, 32'hFFFF_FFFF); m_fen = 3'b111;
        check_state("R8_R9 write ignores status bits");
        do_rd(12'hD24, d, b); chk("R9 no stray bits", d, exp_hstat('0, '0, 3'b111));

        // R9: exhaustive status flag sweep
        do_wr(12'hD24, 32'h0002_0000); m_fen = 3'b010;
        for (int a = 0; a < 128; a++) begin
            for (int p = 0; p < 16; p++) begin
                exc_active = 7'(a);
                exc_pending = 4'(p);
                do_rd(12'hD24, d, b);
                chk("R9 status", d, exp_hstat(7'(a), 4'(p), m_fen));
            end
        end
        exc_active = '0; exc_pending = '0;

        // R10: writes to unmapped offsets leave everything alone
        do_wr(12'hD28, 32'hFFFF_FFFF); check_state("R10");
        do_wr(12'hD10, 32'h05FA_0005); check_state("R10");
        do_wr(12'hD2C, 32'h05FA_0007); check_state("R10");
        do_wr(12'hD3C, 32'h0007_0000); check_state("R10");
        do_wr(12'hD19, 32'hFFFF_FFFF); check_state("R10");
        do_wr(12'hD14, 32'hFFFF_FFFF); check_state("R10");

        // R1: reset again with nonzero state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model_reset();
        check_state("R1 second reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule